// File: doc/BRIEF.md
# Carrier Quadrature Modulator with Output Gain

This block turns a stream of baseband in-phase and quadrature samples into one real sample per clock for a digital-to-analog converter. A 32-bit phase accumulator advances by a programmable frequency tuning word on every clock. The upper ten bits of the phase drive a synthesizable sine/cosine generator, which is a parabolic approximation computed in logic and needs no stored table. The carrier then mixes with the baseband pair, or replaces it, or is bypassed, depending on the selected operating mode. The chosen value is multiplied by an unsigned gain with seven fraction bits and clamped to the 12-bit signed output range.

The tuning word arrives one byte at a time through a small write port. Bytes collect in a shadow register, and the running carrier sees a new word only once every byte lane has been written since the last transfer. The pass-through mode lets an upstream interpolator drive the converter directly, through the same gain stage. The single-tone mode outputs the cosine carrier on its own.

Top module: `nco_quad_mod`

## Requirements
- R1: While reset is asserted, and until the pipeline fills with data after release, `dac_out` is 0. The phase accumulator and the active tuning word both reset to 0.
- R2: A byte written with `ftw_wr_sel` = n lands in tuning-word bits [8n+7:8n]. Lane 0 holds the least significant byte. The active word changes only on the clock edge that completes the set of all four lanes written since the previous transfer, and the lanes may come in any order. Partial writes leave the carrier unchanged.
- R3: On every clock the phase accumulator adds the active tuning word, modulo 2^32. The phase index is accumulator bits [31:22].
- R4: For an index p in 0..1023, sine(p) = ±floor(2047·u·(512−u)/65536), where u = p mod 512. The sign is negative when p ≥ 512. cosine(p) = sine((p+256) mod 1024).
- R5: In mode 0 (quadrature) with `spec_inv` = 0, the pre-gain value is floor((I·cos − Q·sin)/2048).
- R6: In mode 0 with `spec_inv` = 1, the pre-gain value is floor((I·cos + Q·sin)/2048).
- R7: In mode 1 (single tone), the pre-gain value is the cosine sample and I and Q are ignored.
- R8: In mode 2 (pass-through), the pre-gain value is I.
- R9: Mode code 3 is invalid and gives an output of 0.
- R10: The output is floor(pre-gain · `scale_fac` / 128), with `scale_fac` unsigned. A gain of 0 gives 0 and a gain of 128 gives unity.
- R11: Results above 2047 or below −2048 saturate to those limits.
- R12: All inputs sampled at clock edge k (I, Q, mode, invert, gain, and the phase held before that edge) determine `dac_out` right after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ftw_wr_en | input | 1 | Tuning-word byte write strobe |
| ftw_wr_sel | input | 2 | Byte lane of the write (0 = least significant) |
| ftw_wr_byte | input | 8 | Byte value to write |
| mode_sel | input | 2 | 0 quadrature, 1 single tone, 2 pass-through, 3 invalid |
| spec_inv | input | 1 | 1 adds the Q term, 0 subtracts it |
| scale_fac | input | 8 | Unsigned output gain, LSB = 2^-7 |
| i_in | input | 12 | Signed in-phase sample |
| q_in | input | 12 | Signed quadrature sample |
| dac_out | output | 12 | Signed scaled, saturated output sample |

## Verification
Every output depends on inputs captured two clock edges earlier. At each edge the bench therefore computes the expected result from the inputs and from its own model of the phase and the byte-lane loader, queues that result due two cycles later, and compares it at the falling edge of that cycle. A tuning-word byte acts on the active word at the edge where it is written, and on the phase one edge after that. The bench's phase model advances in the same order, so carrier changes are checked at the exact cycle they become due.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_TONE = 2'd1,
    MODE_PASS = 2'd2,
    MODE_BAD  = 2'd3
  } nco_mode_e;
endpackage

// File: rtl/ftw_shadow.sv
// Byte-lane loader: lanes collect in a shadow copy, and the active word is
// replaced once every lane has been written since the last transfer.
module ftw_shadow #(
  parameter int FTW_W  = 32,
  parameter int LANE_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(FTW_W/LANE_W)-1:0]      wr_sel,
  input  logic [LANE_W-1:0]                    wr_data,
  output logic [FTW_W-1:0]                     ftw_act
);
  localparam int LANES = FTW_W / LANE_W;

  logic [LANES-1:0][LANE_W-1:0] shadow_q, shadow_d;
  logic [LANES-1:0]             seen_q, seen_d;
  logic [FTW_W-1:0]             act_q, act_d;

  always_comb begin
    shadow_d = shadow_q;
    seen_d   = seen_q;
    act_d    = act_q;
    if (wr_en) begin
      shadow_d[wr_sel] = wr_data;
      seen_d[wr_sel]   = 1'b1;
      if (&seen_d) begin
        act_d  = shadow_d;
        seen_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      seen_q   <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      seen_q   <= seen_d;
      act_q    <= act_d;
    end
  end

  assign ftw_act = act_q;
endmodule

// File: rtl/phase_accum.sv
// Free-running phase accumulator; wraps naturally at 2^ACC_W.
module phase_accum #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ACC_W-1:0]   ftw,
  output logic [PHASE_W-1:0] phase_idx
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    acc_d = acc_q;
    if (adv_en) acc_d = acc_q + ftw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase_idx = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/sine_gen.sv
// Parabolic sine: each half cycle is 4u(H-u)/H^2 scaled to the peak,
// negated in the second half. Exact zeros and peaks at the quadrant points.
module sine_gen #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 12
) (
  input  logic [PHASE_W-1:0]      idx,
  output logic signed [AMP_W-1:0] wave
);
  localparam int HALF_W = PHASE_W - 1;
  localparam int SHIFT  = 2 * HALF_W - 2;
  localparam int PEAK   = 2 ** (AMP_W - 1) - 1;
  localparam int PW     = 2 * HALF_W + AMP_W;

  logic [HALF_W-1:0] pos;
  logic [HALF_W:0]   rest;
  logic [PW-1:0]     prod;
  logic [AMP_W-1:0]  mag;

  always_comb begin
    pos  = idx[HALF_W-1:0];
    rest = {1'b1, {HALF_W{1'b0}}} - {1'b0, pos};
    prod = PW'(pos) * PW'(rest) * PW'(PEAK);
    mag  = AMP_W'(prod >> SHIFT);
    wave = idx[PHASE_W-1] ? -$signed(mag) : $signed(mag);
  end
endmodule

// File: rtl/quad_mixer.sv
// Stage 1 captures samples, carrier and settings together; stage 2 forms
// the mode-selected pre-gain value.
module quad_mixer
  import nco_pkg::*;
#(
  parameter int IQ_W    = 12,
  parameter int TRIG_W  = 12,
  parameter int SCALE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [IQ_W-1:0]   i_in,
  input  logic signed [IQ_W-1:0]   q_in,
  input  logic signed [TRIG_W-1:0] cos_in,
  input  logic signed [TRIG_W-1:0] sin_in,
  input  logic [1:0]               mode_in,
  input  logic                     inv_in,
  input  logic [SCALE_W-1:0]       scale_in,
  output logic signed [IQ_W+1:0]   mix_o,
  output logic [SCALE_W-1:0]       scale_o
);
  localparam int PROD_W = IQ_W + TRIG_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int MIX_W  = IQ_W + 2;

  // stage 1
  logic signed [IQ_W-1:0]   i1_q, q1_q, i1_d, q1_d;
  logic signed [TRIG_W-1:0] c1_q, s1_q, c1_d, s1_d;
  nco_mode_e                m1_q, m1_d;
  logic                     inv1_q, inv1_d;
  logic [SCALE_W-1:0]       sc1_q, sc1_d;
  // stage 2
  logic signed [MIX_W-1:0]  mix2_q, mix2_d;
  logic [SCALE_W-1:0]       sc2_q, sc2_d;

  logic signed [PROD_W-1:0] prod_i, prod_q;
  logic signed [SUM_W-1:0]  ext_i, ext_q, sum;
  logic signed [MIX_W-1:0]  quad_v;
  logic                     cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    i1_d = i1_q; q1_d = q1_q; c1_d = c1_q; s1_d = s1_q;
    m1_d = m1_q; inv1_d = inv1_q; sc1_d = sc1_q;
    if (cap_en) begin
      i1_d   = i_in;
      q1_d   = q_in;
      c1_d   = cos_in;
      s1_d   = sin_in;
      m1_d   = nco_mode_e'(mode_in);
      inv1_d = inv_in;
      sc1_d  = scale_in;
    end
  end

  always_comb begin
    prod_i = i1_q * c1_q;
    prod_q = q1_q * s1_q;
    ext_i  = {prod_i[PROD_W-1], prod_i};
    ext_q  = {prod_q[PROD_W-1], prod_q};
    sum    = inv1_q ? (ext_i + ext_q) : (ext_i - ext_q);
    quad_v = sum[SUM_W-1:TRIG_W-1];
    unique case (m1_q)
      MODE_QUAD: mix2_d = quad_v;
      MODE_TONE: mix2_d = {{(MIX_W-TRIG_W){c1_q[TRIG_W-1]}}, c1_q};
      MODE_PASS: mix2_d = {{(MIX_W-IQ_W){i1_q[IQ_W-1]}}, i1_q};
      default:   mix2_d = '0;
    endcase
    sc2_d = sc1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i1_q   <= '0;
      q1_q   <= '0;
      c1_q   <= '0;
      s1_q   <= '0;
      m1_q   <= MODE_BAD;
      inv1_q <= 1'b0;
      sc1_q  <= '0;
      mix2_q <= '0;
      sc2_q  <= '0;
    end else begin
      i1_q   <= i1_d;
      q1_q   <= q1_d;
      c1_q   <= c1_d;
      s1_q   <= s1_d;
      m1_q   <= m1_d;
      inv1_q <= inv1_d;
      sc1_q  <= sc1_d;
      mix2_q <= mix2_d;
      sc2_q  <= sc2_d;
    end
  end

  assign mix_o   = mix2_q;
  assign scale_o = sc2_q;
endmodule

// File: rtl/gain_sat.sv
// Stage 3: unsigned fixed-point gain, floor shift, clamp to output range.
module gain_sat #(
  parameter int MIX_W      = 14,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 7,
  parameter int OUT_W      = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [MIX_W-1:0]  mix_in,
  input  logic [SCALE_W-1:0]       scale_in,
  output logic signed [OUT_W-1:0]  out_o
);
  localparam int PRD_W = MIX_W + SCALE_W + 1;
  localparam int SH_W  = PRD_W - SCALE_FRAC;
  localparam logic signed [SH_W-1:0] MAX_S = SH_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [SH_W-1:0] MIN_S = SH_W'(-(2 ** (OUT_W - 1)));

  logic signed [PRD_W-1:0] prod;
  logic signed [SH_W-1:0]  shifted;
  logic signed [OUT_W-1:0] out_q, out_d;
  logic                    out_en;

  assign out_en = 1'b1;

  always_comb begin
    prod    = mix_in * $signed({1'b0, scale_in});
    shifted = prod[PRD_W-1:SCALE_FRAC];
    out_d   = out_q;
    if (out_en) begin
      if (shifted > MAX_S)      out_d = MAX_S[OUT_W-1:0];
      else if (shifted < MIN_S) out_d = MIN_S[OUT_W-1:0];
      else                      out_d = shifted[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/nco_quad_mod.sv
module nco_quad_mod #(
  parameter int FTW_W      = 32,
  parameter int LANE_W     = 8,
  parameter int PHASE_W    = 10,
  parameter int IQ_W       = 12,
  parameter int TRIG_W     = 12,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 7,
  parameter int OUT_W      = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ftw_wr_en,
  input  logic [$clog2(FTW_W/LANE_W)-1:0]     ftw_wr_sel,
  input  logic [LANE_W-1:0]                   ftw_wr_byte,
  input  logic [1:0]                          mode_sel,
  input  logic                                spec_inv,
  input  logic [SCALE_W-1:0]                  scale_fac,
  input  logic signed [IQ_W-1:0]              i_in,
  input  logic signed [IQ_W-1:0]              q_in,
  output logic signed [OUT_W-1:0]             dac_out
);
  localparam int MIX_W = IQ_W + 2;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

  logic                       rst_meta, rst_sync_n;
  logic [FTW_W-1:0]           ftw_act;
  logic [PHASE_W-1:0]         phase_idx;
  logic [1:0][PHASE_W-1:0]    trig_idx;
  logic signed [TRIG_W-1:0]   trig_val [2];
  logic signed [MIX_W-1:0]    mix_v;
  logic [SCALE_W-1:0]         scale_v;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ftw_shadow #(.FTW_W(FTW_W), .LANE_W(LANE_W)) u_ftw (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ftw_wr_en), .wr_sel(ftw_wr_sel),
    .wr_data(ftw_wr_byte), .ftw_act(ftw_act)
  );

  phase_accum #(.ACC_W(FTW_W), .PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .ftw(ftw_act), .phase_idx(phase_idx)
  );

  // entry 0 = sine, entry 1 = cosine (quarter-turn ahead)
  assign trig_idx[0] = phase_idx;
  assign trig_idx[1] = phase_idx + QUARTER;

  for (genvar g = 0; g < 2; g++) begin : g_trig
    sine_gen #(.PHASE_W(PHASE_W), .AMP_W(TRIG_W)) u_sin (
      .idx(trig_idx[g]), .wave(trig_val[g])
    );
  end

  quad_mixer #(.IQ_W(IQ_W), .TRIG_W(TRIG_W), .SCALE_W(SCALE_W)) u_mix (
    .clk(clk), .rst_n(rst_sync_n), .i_in(i_in), .q_in(q_in),
    .cos_in(trig_val[1]), .sin_in(trig_val[0]), .mode_in(mode_sel),
    .inv_in(spec_inv), .scale_in(scale_fac), .mix_o(mix_v), .scale_o(scale_v)
  );

  gain_sat #(.MIX_W(MIX_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC),
             .OUT_W(OUT_W)) u_gain (
    .clk(clk), .rst_n(rst_sync_n), .mix_in(mix_v), .scale_in(scale_v),
    .out_o(dac_out)
  );
endmodule

// File: rtl/nco_quad_mod_chk.sv
module nco_quad_mod_chk #(
  parameter int IQ_W       = 12,
  parameter int OUT_W      = 12,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 7,
  parameter int FTW_W      = 32
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic [1:0]              mode_sel,
  input logic [SCALE_W-1:0]      scale_fac,
  input logic signed [IQ_W-1:0]  i_in,
  input logic signed [OUT_W-1:0] dac_out,
  input logic                    ftw_wr_en,
  input logic [FTW_W-1:0]        ftw_act
);
  localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << SCALE_FRAC;

  logic [2:0] age_q;
  logic       age_full;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    age_q <= '0;
    else if (!age_q[2]) age_q <= age_q + 3'd1;
  end
  assign age_full = age_q[2];

  // R9
  bad_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_full && $past(mode_sel, 3) == 2'd3) |-> (dac_out == '0));

  // R10
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_full && $past(scale_fac, 3) == '0) |-> (dac_out == '0));

  // R8
  pass_unity_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_full && $past(mode_sel, 3) == 2'd2 && $past(scale_fac, 3) == UNITY)
      |-> (dac_out == OUT_W'($past(i_in, 3))));

  // R2
  ftw_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_full && !$past(ftw_wr_en)) |-> $stable(ftw_act));
endmodule

bind nco_quad_mod nco_quad_mod_chk #(
  .IQ_W(IQ_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC),
  .FTW_W(FTW_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .mode_sel(mode_sel),
  .scale_fac(scale_fac), .i_in(i_in), .dac_out(dac_out),
  .ftw_wr_en(ftw_wr_en), .ftw_act(ftw_act)
);

// File: tb/tb_nco_quad_mod.sv
`timescale 1ns/1ps
module tb_nco_quad_mod;
  logic               clk;
  logic               rst_n;
  logic               ftw_wr_en;
  logic [1:0]         ftw_wr_sel;
  logic [7:0]         ftw_wr_byte;
  logic [1:0]         mode_sel;
  logic               spec_inv;
  logic [7:0]         scale_fac;
  logic signed [11:0] i_in, q_in;
  logic signed [11:0] dac_out;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    model_on = 0;
  bit    done     = 0;
  string cur_tag  = "R1";

  // scoreboard queues (pushed together, popped together)
  int    due_q [$];
  int    exp_q [$];
  string tag_q [$];

  // bench model state
  logic [31:0] acc_m  = '0;
  logic [31:0] act_m  = '0;
  logic [7:0]  shd_m [4];
  logic [3:0]  seen_m = '0;

  nco_quad_mod dut (
    .clk(clk), .rst_n(rst_n), .ftw_wr_en(ftw_wr_en), .ftw_wr_sel(ftw_wr_sel),
    .ftw_wr_byte(ftw_wr_byte), .mode_sel(mode_sel), .spec_inv(spec_inv),
    .scale_fac(scale_fac), .i_in(i_in), .q_in(q_in), .dac_out(dac_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R4 sine shape
  function automatic int psin(input int p);
    int u, mag;
    u   = p % 512;
    mag = (2047 * u * (512 - u)) >>> 16;
    return (p >= 512) ? -mag : mag;
  endfunction

  function automatic int ref_out(input int md, input int inv, input int scl,
                                 input int iv, input int qv, input logic [31:0] acc);
    int idx, c, s, mix, y;
    idx = int'(acc[31:22]);
    c   = psin((idx + 256) % 1024);
    s   = psin(idx);
    case (md)
      0:       mix = (iv * c + ((inv != 0) ? qv * s : -(qv * s))) >>> 11; // R5 / R6
      1:       mix = c;                                                  // R7
      2:       mix = iv;                                                 // R8
      default: mix = 0;                                                  // R9
    endcase
    y = (mix * scl) >>> 7;                                               // R10
    if (y > 2047)  y = 2047;                                             // R11
    if (y < -2048) y = -2048;
    return y;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: dac_out=%0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver-side model: at each edge, predict the output due two edges later (R12)
  always @(posedge clk) begin
    cyc++;
    if (model_on) begin
      due_q.push_back(cyc + 2);
      exp_q.push_back(ref_out(int'(mode_sel), int'(spec_inv), int'(scale_fac),
                              int'(i_in), int'(q_in), acc_m));
      tag_q.push_back(cur_tag);
      acc_m = acc_m + act_m;                       // R3
      if (ftw_wr_en) begin                         // R2
        shd_m[ftw_wr_sel] = ftw_wr_byte;
        seen_m[ftw_wr_sel] = 1'b1;
        if (seen_m == 4'hF) begin
          act_m  = {shd_m[3], shd_m[2], shd_m[1], shd_m[0]};
          seen_m = '0;
        end
      end
    end
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check(tag_q[0], int'(dac_out), exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic write_lane(input int lane, input logic [7:0] b);
    @(negedge clk);
    ftw_wr_en   = 1'b1;
    ftw_wr_sel  = lane[1:0];
    ftw_wr_byte = b;
    @(negedge clk);
    ftw_wr_en   = 1'b0;
  endtask

  task automatic write_ftw(input logic [31:0] w);
    for (int k = 0; k < 4; k++) write_lane(k, w[8*k +: 8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_iq(input int n, input int mi, input int mq);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_in = 12'((k * mi + 91) % 4096);
      q_in = 12'((k * mq + 1500) % 4096);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ftw_wr_en = 1'b0; ftw_wr_sel = '0; ftw_wr_byte = '0;
    mode_sel = 2'd0; spec_inv = 1'b0; scale_fac = 8'd0; i_in = '0; q_in = '0;
    for (int k = 0; k < 4; k++) shd_m[k] = '0;

    // R1: output held at zero in reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1 in reset", int'(dac_out), 0);
    end
    rst_n = 1'b1;
    idle(5);
    check("R1 after release", int'(dac_out), 0);

    // R7: tone at phase 0 -> cosine peak, unity gain; I/Q ignored
    cur_tag = "R7"; mode_sel = 2'd1; scale_fac = 8'd128; i_in = 12'sd900; q_in = -12'sd700;
    model_on = 1'b1;
    idle(6);

    // R2 full load, then R3 quarter-turn stepping
    cur_tag = "R2"; write_ftw(32'h4000_0000);
    cur_tag = "R3"; idle(12);

    // R2 partial load: three lanes must not change the carrier
    cur_tag = "R2 partial";
    write_lane(0, 8'h00); write_lane(1, 8'h00); write_lane(2, 8'h00);
    idle(8);
    cur_tag = "R2 commit"; write_lane(3, 8'h08);
    idle(6);

    // R4 fine steps across the wave, lanes written out of order
    cur_tag = "R4";
    write_lane(3, 8'h01); write_lane(1, 8'h00); write_lane(0, 8'h00); write_lane(2, 8'h00);
    idle(70);

    // R3 wrap of the accumulator
    cur_tag = "R3 wrap"; write_ftw(32'hC000_0000); idle(10);

    // R5 / R6 quadrature
    write_ftw(32'h0123_4567);
    cur_tag = "R5"; mode_sel = 2'd0; spec_inv = 1'b0; drive_iq(40, 373, 811);
    cur_tag = "R6"; spec_inv = 1'b1; drive_iq(40, 517, 229);

    // R8 pass-through
    cur_tag = "R8"; mode_sel = 2'd2; spec_inv = 1'b0; drive_iq(20, 619, 101);

    // R9 invalid mode
    cur_tag = "R9"; mode_sel = 2'd3; scale_fac = 8'd200; drive_iq(10, 733, 97);

    // R10 gain values
    mode_sel = 2'd2;
    cur_tag = "R10 gain0";   scale_fac = 8'd0;   drive_iq(8, 401, 3);
    cur_tag = "R10 gain64";  scale_fac = 8'd64;  drive_iq(8, 401, 3);
    cur_tag = "R10 gain200"; scale_fac = 8'd200; drive_iq(8, 257, 3);

    // R11 saturation at both limits
    cur_tag = "R11 high"; scale_fac = 8'd255; i_in = 12'sd2047;  idle(5);
    cur_tag = "R11 low";  i_in = -12'sd2048; idle(5);
    cur_tag = "R11 quad"; mode_sel = 2'd0; i_in = 12'sd2047; q_in = -12'sd2048; idle(20);

    // R12 impulse latency
    cur_tag = "R12"; mode_sel = 2'd2; scale_fac = 8'd128; i_in = '0; idle(3);
    i_in = 12'sd777; idle(1);
    i_in = '0; idle(6);

    model_on = 1'b0;
    idle(4);
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d results never compared, expected 0", due_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule